// File: doc/BRIEF.md
# Retired-Instruction Mix Profiling Counters

This block sits beside the writeback stage of a small RV32 pipeline and tallies what retires. On each clock it looks at one flag, set when a real instruction leaves the pipeline and clear when the slot is an empty bubble that the machine inserted (for example after a taken branch squashes a fetched instruction), together with the 32-bit word that retired. It then sorts that word into one of five classes: software NOP, arithmetic, memory access, conditional branch, or other. A separate tally records memory accesses whose immediate offset is not zero. These are the accesses that would need an extra add if addressing were limited to a bare base register.

A cycle tally runs on every enabled cycle and gives the common denominator for the class fractions. Software reads the counters and computes the percentages, CPI and IPC itself. All counting is gated by a statistics-enable bit that a control register drives. A synchronous clear zeroes every counter, and the counters saturate instead of wrapping. Counters are read by index, and the value appears on the data output one cycle later.

Top module: `retire_mix_profiler`

## Requirements
- R1: After reset every counter is zero and `rd_data` is zero.
- R2: Counter index 0 (cycles) rises by one on each clock edge where `stats_en` is 1, whatever `ret_valid` is.
- R3: An enabled cycle with `ret_valid` = 0 raises counter index 1 (bubbles) and no class counter (indices 2 to 7).
- R4: The exact word 0x00000013 with `ret_valid` = 1 raises counter index 2 (NOP) and not the arithmetic counter. Any other word with the same opcode is arithmetic.
- R5: Opcodes [6:0] of 0010011, 0110011, 0110111 and 0010111 raise counter index 3 (arithmetic).
- R6: Opcodes 0000011 (load) and 0100011 (store) raise counter index 4 (memory).
- R7: Opcode 1100011 raises counter index 5 (branch).
- R8: Every other opcode raises counter index 6 (other). Exactly one of indices 2 to 6 rises per enabled retiring instruction.
- R9: Counter index 7 also rises for a load whose offset bits [31:20] are not all zero, or a store whose offset {[31:25],[11:7]} is not zero.
- R10: While `stats_en` is 0 no counter changes.
- R11: `clr` = 1 zeroes all counters at the next edge, even when an increment is requested in the same cycle.
- R12: A counter at its all-ones value stays there on further increments.
- R13: `rd_data` presents counter `rd_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stats_en | input | 1 | Statistics-enable control bit |
| clr | input | 1 | Synchronous clear of all counters |
| ret_valid | input | 1 | 1 = instruction retires, 0 = bubble |
| ret_insn | input | 32 | Retiring instruction word |
| rd_addr | input | $clog2(8) | Counter index to read |
| rd_data | output | CNT_W | Registered counter value |

## Verification
A misclassification raises the wrong counter by exactly one per instruction, so every opcode is retired in its own short batch and all eight counters are read back before the next batch. An error therefore shows up within one batch, about a dozen cycles. A broken enable, clear or saturation path leaves a counter that differs from the arithmetic expectation at the first read after the stimulus. A wrong read latency shows up as the previous address's value on the first sample.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

   localparam int NUM_CNT = 8;

   typedef enum logic [2:0] {
      IDX_CYCLE   = 3'd0,
      IDX_BUBBLE  = 3'd1,
      IDX_NOP     = 3'd2,
      IDX_ALU     = 3'd3,
      IDX_MEM     = 3'd4,
      IDX_BRANCH  = 3'd5,
      IDX_OTHER   = 3'd6,
      IDX_MEM_OFS = 3'd7
   } cnt_idx_e;

   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

   localparam logic [31:0] NOP_WORD  = 32'h0000_0013;

endpackage

// File: rtl/rmp_classify.sv
module rmp_classify
   import rmp_pkg::*;
(
   input  logic [31:0]        insn,
   output logic [NUM_CNT-1:0] hit
);

   logic [6:0]  opc;
   logic [11:0] ld_ofs;
   logic [11:0] st_ofs;

   assign opc    = insn[6:0];
   assign ld_ofs = insn[31:20];
   assign st_ofs = {insn[31:25], insn[11:7]};

   always_comb begin
      hit = '0;
      if (insn == NOP_WORD) begin
         hit[IDX_NOP] = 1'b1;
      end else begin
         case (opc)
            OPC_IMM, OPC_REG, OPC_LUI, OPC_AUIPC: hit[IDX_ALU] = 1'b1;
            OPC_LOAD: begin
               hit[IDX_MEM]     = 1'b1;
               hit[IDX_MEM_OFS] = |ld_ofs;
            end
            OPC_STORE: begin
               hit[IDX_MEM]     = 1'b1;
               hit[IDX_MEM_OFS] = |st_ofs;
            end
            OPC_BRANCH: hit[IDX_BRANCH] = 1'b1;
            default:    hit[IDX_OTHER]  = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/rmp_counter.sv
module rmp_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] MAX = '1;

   generate
      if (W < 2) begin : g_bad_width
         $error("rmp_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (cnt == MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (inc)    cnt <= nxt;
   end

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && cnt != MAX) |=> (cnt == $past(cnt) + 1'b1));

   generate
      if (SATURATE) begin : g_sat_chk
         p_saturate_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && cnt == MAX) |=> (cnt == MAX));
      end
   endgenerate

endmodule

// File: rtl/rmp_read_port.sv
module rmp_read_port #(
   parameter int W = 32,
   parameter int N = 8,
   localparam int AW = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  addr,
   input  logic [N*W-1:0] cnt_flat,
   output logic [W-1:0]   data
);

   logic [W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < N; i++) begin
         if (addr == AW'(i)) sel = cnt_flat[i*W +: W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data <= '0;
      else        data <= sel;
   end

endmodule

// File: rtl/retire_mix_profiler.sv
module retire_mix_profiler
   import rmp_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stats_en,
   input  logic              clr,
   input  logic              ret_valid,
   input  logic [31:0]       ret_insn,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data
);

   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
         $error("retire_mix_profiler: CNT_W out of range");
      end
   endgenerate

   logic [NUM_CNT-1:0]       hit;
   logic [NUM_CNT-1:0]       inc;
   logic [CNT_W-1:0]         cnt_q [NUM_CNT];
   logic [NUM_CNT*CNT_W-1:0] cnt_flat;

   rmp_classify u_cls (
      .insn (ret_insn),
      .hit  (hit)
   );

   always_comb begin
      inc = '0;
      if (stats_en) begin
         inc[IDX_CYCLE] = 1'b1;
         if (ret_valid) inc = inc | hit;
         else           inc[IDX_BUBBLE] = 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
         rmp_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc[g]),
            .cnt   (cnt_q[g])
         );
         assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
      end
   endgenerate

   rmp_read_port #(.W(CNT_W), .N(NUM_CNT)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (rd_addr),
      .cnt_flat (cnt_flat),
      .data     (rd_data)
   );

   p_bubble_no_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stats_en && !ret_valid && !clr) |=>
         ($stable(cnt_q[IDX_NOP]) && $stable(cnt_q[IDX_ALU]) &&
          $stable(cnt_q[IDX_MEM]) && $stable(cnt_q[IDX_BRANCH]) &&
          $stable(cnt_q[IDX_OTHER]) && $stable(cnt_q[IDX_MEM_OFS])));

   p_one_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> ($countones(hit[IDX_OTHER:IDX_NOP]) == 1));

   p_ofs_only_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit[IDX_MEM_OFS] |-> hit[IDX_MEM]);

   p_idle_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stats_en && !clr) |=> $stable(cnt_q[IDX_CYCLE]));

endmodule

// File: tb/retire_mix_profiler_bench.sv
`timescale 1ns/1ps
module retire_mix_profiler_bench;

   localparam int CW   = 6;
   localparam int MAXV = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stats_en = 1'b0;
   logic          clr = 1'b0;
   logic          ret_valid = 1'b0;
   logic [31:0]   ret_insn = '0;
   logic [2:0]    rd_addr = '0;
   logic [CW-1:0] rd_data;

   int n_run  = 0;
   int n_fail = 0;
   int expc [8];
   int wd_cycles = 0;

   always #2 clk = ~clk;

   retire_mix_profiler #(.CNT_W(CW), .SATURATE(1'b1)) u_retire_mix_profiler (
      .clk       (clk),
      .rst_n     (rst_n),
      .stats_en  (stats_en),
      .clr       (clr),
      .ret_valid (ret_valid),
      .ret_insn  (ret_insn),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Class index from the requirement text: R4 NOP, R5 arith, R6 mem, R7 branch, R8 other
   function automatic int class_of(input logic [31:0] w);
      if (w == 32'h0000_0013) return 2;
      case (w[6:0])
         7'b0010011, 7'b0110011, 7'b0110111, 7'b0010111: return 3;
         7'b0000011, 7'b0100011: return 4;
         7'b1100011: return 5;
         default: return 6;
      endcase
   endfunction

   function automatic bit ofs_nz(input logic [31:0] w);
      if (w[6:0] == 7'b0000011) return (w[31:20] != 12'h0);
      if (w[6:0] == 7'b0100011) return ({w[31:25], w[11:7]} != 12'h0);
      return 1'b0;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 8; i++) expc[i] = 0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr = 1'b1; stats_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0;
      model_clear();
   endtask

   task automatic retire(input logic v, input logic [31:0] w, input logic en);
      @(negedge clk);
      stats_en = en; ret_valid = v; ret_insn = w;
      @(posedge clk);
      if (en) begin
         expc[0]++;
         if (!v) expc[1]++;
         else begin
            expc[class_of(w)]++;
            if (ofs_nz(w)) expc[7]++;
         end
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      stats_en = 1'b0; ret_valid = 1'b0;
   endtask

   task automatic read_cnt(input int idx, output int val);
      @(negedge clk);
      rd_addr = 3'(idx);
      @(posedge clk);
      @(negedge clk);
      val = int'(rd_data);
   endtask

   task automatic check_all(input string req);
      int v;
      for (int i = 0; i < 8; i++) begin
         read_cnt(i, v);
         check($sformatf("%s idx%0d", req, i), v, (expc[i] > MAXV) ? MAXV : expc[i]);
      end
   endtask

   always @(posedge clk) begin
      wd_cycles++;
      if (wd_cycles > 150000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", wd_cycles, 150000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      int a;
      int b;
      #1;
      // R1: reset state
      check("R1 rd_data in reset", int'(rd_data), 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_clear();
      check_all("R1 reset");

      // R2 R3 R5 R6 R7 R8 R9: sweep of all 128 opcodes
      for (int op = 0; op < 128; op++) begin
         do_clear();
         retire(1'b0, 32'hFFFF_FFFF, 1'b1);
         retire(1'b1, {25'h0, 7'(op)}, 1'b1);
         retire(1'b1, {12'h800, 13'h0, 7'(op)}, 1'b1);
         retire(1'b1, {20'h0, 5'h01, 7'(op)}, 1'b1);
         go_idle();
         check_all($sformatf("R2/R3/R5-R9 opcode %0d", op));
      end

      // R4: exact NOP word versus near neighbours
      do_clear();
      retire(1'b1, 32'h0000_0013, 1'b1);
      retire(1'b1, 32'h0000_0093, 1'b1);
      retire(1'b1, 32'h0010_0013, 1'b1);
      retire(1'b1, 32'h0000_0013, 1'b1);
      go_idle();
      read_cnt(2, v); check("R4 nop count", v, 2);
      read_cnt(3, v); check("R4 arith count", v, 2);

      // R10: disabled cycles change nothing
      do_clear();
      retire(1'b1, 32'h0010_0013, 1'b0);
      retire(1'b0, 32'h0, 1'b0);
      retire(1'b1, 32'h0040_2003, 1'b0);
      go_idle();
      check_all("R10 disabled");
      retire(1'b1, 32'h0010_0013, 1'b1);
      go_idle();
      read_cnt(3, v); check("R10 enabled again arith", v, 1);
      read_cnt(0, v); check("R10 enabled again cycles", v, 1);

      // R11: clear wins over a simultaneous increment
      do_clear();
      for (int i = 0; i < 5; i++) retire(1'b1, 32'h0010_0013, 1'b1);
      @(negedge clk);
      clr = 1'b1; stats_en = 1'b1; ret_valid = 1'b1; ret_insn = 32'h0010_0013;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0; stats_en = 1'b0; ret_valid = 1'b0;
      model_clear();
      check_all("R11 clear wins");

      // R12: saturation at all ones
      do_clear();
      for (int i = 0; i < MAXV + 7; i++) retire(1'b1, 32'h0000_0013, 1'b1);
      go_idle();
      read_cnt(0, v); check("R12 cycles saturate", v, MAXV);
      read_cnt(2, v); check("R12 nop saturate", v, MAXV);
      read_cnt(1, v); check("R12 bubbles untouched", v, 0);

      // R13: one-cycle read latency
      do_clear();
      for (int i = 0; i < 3; i++) retire(1'b0, 32'h0, 1'b1);
      retire(1'b1, 32'h0000_0063, 1'b1);
      go_idle();
      read_cnt(1, a);
      check("R13 bubbles", a, 3);
      @(negedge clk);
      rd_addr = 3'd0;
      #0.5;
      b = int'(rd_data);
      check("R13 old value before edge", b, 3);
      @(posedge clk);
      @(negedge clk);
      check("R13 new value after edge", int'(rd_data), 4);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule